// File: doc/BRIEF.md
# Master Data Byte Queue

This block is a small shift-register queue that holds the bytes a bus master sends or receives. It has room for four bytes by default. The host reaches it through one register slot. Each host write appends a byte. Each qualified host read returns the oldest byte and moves the remaining bytes one place toward the head. A flush command empties the queue. The transfer engine can also back-load the queue directly: after a receive it writes N bytes in parallel and sets the fill level to N.

The fill level counts from 0 (empty) to DEPTH (full). It equals the classic fill index plus one. Two sticky status flags, "holding data" and "full", change only on specific fill transitions and are not recomputed from the level. This gives the engine's status model exactly. For example, an engine load of zero bytes empties the queue but leaves a previously set "holding data" flag standing.

Top module: `master_data_buffer`

## Requirements
- R1: After reset the fill level is 0, both flags are low and `rd_data` is all ones.
- R2: A host write when the level is below DEPTH stores `wr_data` at position `level` (position 0 is the head) and raises the level by one. A host write at level DEPTH is ignored: level, flags and contents are unchanged.
- R3: A write that brings the level to DEPTH sets `full`. A write that brings the level to 1 sets `has_data`. Other writes leave both flags as they are.
- R4: While the level is 0, `rd_data` is all ones, and a read strobe changes neither the level, the flags nor the contents.
- R5: While the level is non-zero, `rd_data` shows the head byte. A read strobe removes it, moves every other stored byte one position toward the head and lowers the level by one. It clears `full` if the level was DEPTH and clears `has_data` if the level was 1.
- R6: A flush sets every stored byte to zero, sets the level to 0 and clears both flags.
- R7: An engine load with count N (0..DEPTH; larger values are treated as DEPTH) writes byte i of `load_data` (bits i*8+7 : i*8) into position i for every i below N. It sets the level to N, sets `has_data` if N is at least 1 and sets `full` if N equals DEPTH. Flags are otherwise unchanged, and positions at or above N keep their contents.
- R8: When several commands arrive in one cycle, one acts and the others are dropped, in this priority: engine load, then flush, then read strobe, then write. A read strobe on an empty queue still takes the cycle, so a write in that cycle is dropped.
- R9: `rd_data` is combinational from the stored state. Looking at it without a read strobe never moves the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | DATA_W | Host write byte |
| rd_en | input | 1 | Qualified host read strobe (pop) |
| rd_data | output | DATA_W | Head byte, all ones when empty |
| flush | input | 1 | Empty the queue |
| load_en | input | 1 | Engine back-load strobe |
| load_count | input | clog2(DEPTH+1) | Number of bytes loaded by the engine |
| load_data | input | DEPTH*DATA_W | Engine bytes, byte i in slice i |
| fill_level | output | clog2(DEPTH+1) | Number of stored bytes |
| has_data | output | 1 | Sticky "holding data" flag |
| full | output | 1 | Sticky "full" flag |

## Verification
The queue is filled to the top and past it, then drained byte by byte. The order of the returned bytes separates a correct shift from a stuck or reversed one, and the flag values at each level separate the transition-driven flags from flags recomputed from the level. Engine loads of three, four and zero bytes, the last one after a host write, show that a load sets the level directly and that `has_data` stays set when nothing is loaded. Commands that collide in one cycle (load with write, flush with load, read with flush, read with write on an empty queue) are followed by reads that show which command won.

// File: rtl/mdb_pkg.sv
package mdb_pkg;
   // One action per cycle, chosen by the arbiter.
   typedef enum logic [2:0] {
      OP_IDLE  = 3'd0,
      OP_WRITE = 3'd1,
      OP_READ  = 3'd2,
      OP_FLUSH = 3'd3,
      OP_LOAD  = 3'd4
   } mdb_op_e;
endpackage

// File: rtl/mdb_op_arbiter.sv
module mdb_op_arbiter
   import mdb_pkg::*;
#(
   parameter int DEPTH = 4,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             flush_i,
   input  logic             rd_i,
   input  logic             wr_i,
   input  logic [CNT_W-1:0] level_i,
   output mdb_op_e          op_o
);
   logic is_empty, is_full;
   assign is_empty = (level_i == '0);
   assign is_full  = (level_i == CNT_W'(DEPTH));

   always_comb begin
      op_o = OP_IDLE;
      if (load_i)                op_o = OP_LOAD;
      else if (flush_i)          op_o = OP_FLUSH;
      else if (rd_i)             op_o = is_empty ? OP_IDLE : OP_READ;
      else if (wr_i && !is_full) op_o = OP_WRITE;
   end

   assert_load_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |-> op_o == OP_LOAD);
   assert_empty_read_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && level_i == '0 && !load_i && !flush_i) |-> op_o == OP_IDLE);
   assert_full_write_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && level_i == CNT_W'(DEPTH) && !load_i && !flush_i && !rd_i) |-> op_o == OP_IDLE);
endmodule

// File: rtl/mdb_level_ctrl.sv
module mdb_level_ctrl
   import mdb_pkg::*;
#(
   parameter int DEPTH = 4,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  mdb_op_e          op_i,
   input  logic [CNT_W-1:0] ld_count_i,
   output logic [CNT_W-1:0] level_o,
   output logic             has_data_o,
   output logic             full_o
);
   localparam logic [CNT_W-1:0] LVL_TOP = CNT_W'(DEPTH);
   localparam logic [CNT_W-1:0] LVL_ONE = CNT_W'(1);

   logic [CNT_W-1:0] level_q;
   logic             has_q, full_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         level_q <= '0;
         has_q   <= 1'b0;
         full_q  <= 1'b0;
      end else begin
         unique case (op_i)
            OP_LOAD: begin
               level_q <= ld_count_i;
               if (ld_count_i != '0)     has_q  <= 1'b1;
               if (ld_count_i == LVL_TOP) full_q <= 1'b1;
            end
            OP_FLUSH: begin
               level_q <= '0;
               has_q   <= 1'b0;
               full_q  <= 1'b0;
            end
            OP_READ: begin
               level_q <= level_q - LVL_ONE;
               if (level_q == LVL_TOP) full_q <= 1'b0;
               if (level_q == LVL_ONE) has_q  <= 1'b0;
            end
            OP_WRITE: begin
               level_q <= level_q + LVL_ONE;
               if (level_q == LVL_TOP - LVL_ONE) full_q <= 1'b1;
               if (level_q == '0)                has_q  <= 1'b1;
            end
            default: ;
         endcase
      end
   end

   assign level_o    = level_q;
   assign has_data_o = has_q;
   assign full_o     = full_q;

   assert_level_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      level_q <= LVL_TOP);
   assert_idle_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      op_i == OP_IDLE |=> ($stable(level_q) && $stable(has_q) && $stable(full_q)));
   assert_write_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      op_i == OP_WRITE |=> level_q == $past(level_q) + LVL_ONE);
   assert_write_fills_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == OP_WRITE && level_q == LVL_TOP - LVL_ONE) |=> full_q);
   assert_last_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == OP_READ && level_q == LVL_ONE) |=> (!has_q && level_q == '0));
   assert_flush_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      op_i == OP_FLUSH |=> (level_q == '0 && !has_q && !full_q));
   assert_load_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
      op_i == OP_LOAD |=> level_q == $past(ld_count_i));
endmodule

// File: rtl/mdb_shift_store.sv
module mdb_shift_store
   import mdb_pkg::*;
#(
   parameter int DEPTH  = 4,
   parameter int DATA_W = 8,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  mdb_op_e                 op_i,
   input  logic [CNT_W-1:0]        level_i,
   input  logic [DATA_W-1:0]       wr_data_i,
   input  logic [CNT_W-1:0]        ld_count_i,
   input  logic [DEPTH*DATA_W-1:0] ld_data_i,
   output logic [DATA_W-1:0]       head_o
);
   logic [DEPTH-1:0][DATA_W-1:0] slot_q;

   for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
      // Byte that moves into this slot on a pop.
      logic [DATA_W-1:0] next_in;
      if (gi == DEPTH - 1) begin : g_tail
         assign next_in = slot_q[gi];
      end else begin : g_body
         assign next_in = slot_q[gi+1];
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            slot_q[gi] <= '0;
         end else begin
            unique case (op_i)
               OP_LOAD:
                  if (CNT_W'(gi) < ld_count_i) slot_q[gi] <= ld_data_i[gi*DATA_W +: DATA_W];
               OP_FLUSH:
                  slot_q[gi] <= '0;
               OP_READ:
                  if (CNT_W'(gi + 1) < level_i) slot_q[gi] <= next_in;
               OP_WRITE:
                  if (level_i == CNT_W'(gi)) slot_q[gi] <= wr_data_i;
               default: ;
            endcase
         end
      end
   end

   assign head_o = slot_q[0];

   assert_flush_zeroes_R6: assert property (@(posedge clk) disable iff (!rst_n)
      op_i == OP_FLUSH |=> slot_q == '0);
   assert_pop_shifts_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == OP_READ && level_i > CNT_W'(1)) |=> head_o == $past(slot_q[1]));
endmodule

// File: rtl/master_data_buffer.sv
module master_data_buffer
   import mdb_pkg::*;
#(
   parameter int DEPTH  = 4,
   parameter int DATA_W = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [DATA_W-1:0]            wr_data,
   input  logic                         rd_en,
   output logic [DATA_W-1:0]            rd_data,
   input  logic                         flush,
   input  logic                         load_en,
   input  logic [$clog2(DEPTH+1)-1:0]   load_count,
   input  logic [DEPTH*DATA_W-1:0]      load_data,
   output logic [$clog2(DEPTH+1)-1:0]   fill_level,
   output logic                         has_data,
   output logic                         full
);
   localparam int CNT_W = $clog2(DEPTH + 1);

   initial begin
      assert (DEPTH >= 2 && DATA_W >= 1)
         else $error("master_data_buffer: DEPTH must be >= 2 and DATA_W >= 1");
   end

   mdb_op_e          op;
   logic [CNT_W-1:0] level;
   logic [CNT_W-1:0] ld_count_eff;
   logic [DATA_W-1:0] head;

   // Counts above the capacity are clamped.
   assign ld_count_eff = (load_count > CNT_W'(DEPTH)) ? CNT_W'(DEPTH) : load_count;

   mdb_op_arbiter #(.DEPTH(DEPTH)) u_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (load_en),
      .flush_i (flush),
      .rd_i    (rd_en),
      .wr_i    (wr_en),
      .level_i (level),
      .op_o    (op)
   );

   mdb_level_ctrl #(.DEPTH(DEPTH)) u_lvl (
      .clk        (clk),
      .rst_n      (rst_n),
      .op_i       (op),
      .ld_count_i (ld_count_eff),
      .level_o    (level),
      .has_data_o (has_data),
      .full_o     (full)
   );

   mdb_shift_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .op_i       (op),
      .level_i    (level),
      .wr_data_i  (wr_data),
      .ld_count_i (ld_count_eff),
      .ld_data_i  (load_data),
      .head_o     (head)
   );

   assign rd_data    = (level == '0) ? '1 : head;
   assign fill_level = level;
endmodule

// File: tb/test_master_data_buffer.sv
module test_master_data_buffer;
   localparam int D  = 4;
   localparam int W  = 8;
   localparam int CW = $clog2(D + 1);

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic            rst_n = 1'b0;
   logic            wr_en = 1'b0, rd_en = 1'b0, flush = 1'b0, load_en = 1'b0;
   logic [W-1:0]    wr_data = '0;
   logic [CW-1:0]   load_count = '0;
   logic [D*W-1:0]  load_data = '0;
   logic [W-1:0]    rd_data;
   logic [CW-1:0]   fill_level;
   logic            has_data, full;

   master_data_buffer #(.DEPTH(D), .DATA_W(W)) i_master_data_buffer (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(rd_en), .rd_data(rd_data), .flush(flush), .load_en(load_en),
      .load_count(load_count), .load_data(load_data),
      .fill_level(fill_level), .has_data(has_data), .full(full)
   );

   int checks = 0, errors = 0;
   bit done = 1'b0;

   // Reference model built from the requirements.
   logic [W-1:0] m [D];
   int  mc  = 0;
   bit  msd = 0, mfl = 0;
   logic [W-1:0] exp_q [$];
   string rd_tag = "R5";

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Monitor: compares every strobed read against the scoreboard.
   always @(negedge clk) begin
      if (rst_n && rd_en) begin
         if (exp_q.size() == 0) begin
            checks++; errors++;
            $display("FAIL %s: actual=%0h expected=none queued", rd_tag, rd_data);
         end else begin
            chk(rd_tag, int'(rd_data), int'(exp_q.pop_front()));
         end
      end
   end

   task automatic op(bit w, logic [W-1:0] wd, bit r, bit f, bit l, int lc, logic [D*W-1:0] ld);
      @(posedge clk); #1;
      wr_en = w; wr_data = wd; rd_en = r; flush = f; load_en = l;
      load_count = CW'(lc); load_data = ld;
      if (r) begin
         rd_tag = (mc == 0) ? "R4" : "R5";
         exp_q.push_back((mc == 0) ? 8'hFF : m[0]);
      end
      @(posedge clk); #1;
      wr_en = 0; rd_en = 0; flush = 0; load_en = 0;
      if (l) begin
         for (int i = 0; i < lc; i++) m[i] = ld[i*W +: W];
         mc = lc;
         if (lc > 0) msd = 1;
         if (lc == D) mfl = 1;
      end else if (f) begin
         for (int i = 0; i < D; i++) m[i] = '0;
         mc = 0; msd = 0; mfl = 0;
      end else if (r) begin
         if (mc > 0) begin
            for (int i = 0; i < D - 1; i++) m[i] = m[i+1];
            if (mc == D) mfl = 0;
            if (mc == 1) msd = 0;
            mc--;
         end
      end else if (w && mc < D) begin
         m[mc] = wd; mc++;
         if (mc == D) mfl = 1;
         if (mc == 1) msd = 1;
      end
   endtask

   task automatic check_state(string req);
      @(negedge clk);
      chk({req, " level"},    int'(fill_level), mc);
      chk({req, " has_data"}, int'(has_data),   int'(msd));
      chk({req, " full"},     int'(full),       int'(mfl));
   endtask

   task automatic wr(logic [W-1:0] b);  op(1, b, 0, 0, 0, 0, '0); endtask
   task automatic rd();                 op(0, '0, 1, 0, 0, 0, '0); endtask
   task automatic fl();                 op(0, '0, 0, 1, 0, 0, '0); endtask
   task automatic ld(int n, logic [D*W-1:0] d); op(0, '0, 0, 0, 1, n, d); endtask

   initial begin
      for (int i = 0; i < D; i++) m[i] = '0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1: reset state
      check_state("R1");
      chk("R1 rd_data", int'(rd_data), 'hFF);

      // R4: read on empty queue
      rd(); check_state("R4");

      // R2/R3: fill to the top
      wr(8'hA1); check_state("R3 first write");
      wr(8'hB2); wr(8'hC3); check_state("R3 no flag change");
      wr(8'hD4); check_state("R3 full set");
      wr(8'hEE); check_state("R2 write when full ignored");

      // R9: look without strobe
      @(negedge clk); chk("R9 peek", int'(rd_data), 'hA1);
      @(negedge clk); chk("R9 peek again", int'(rd_data), 'hA1);
      chk("R9 level", int'(fill_level), D);

      // R5: drain in order
      rd(); check_state("R5 full cleared");
      rd(); rd(); check_state("R5 partial");
      rd(); check_state("R5 last pop");
      rd(); check_state("R4 empty again");

      // R6: flush
      wr(8'h11); wr(8'h22); fl(); check_state("R6 flush");
      rd();

      // R7: engine loads
      ld(3, 32'h00_77_66_55); check_state("R7 load three");
      rd(); rd(); rd(); check_state("R7 drained");
      ld(4, 32'h44_33_22_11); check_state("R7 load four");
      rd(); check_state("R7 pop after load");
      fl(); wr(8'h99); ld(0, '0); check_state("R7 load zero keeps has_data");
      rd(); check_state("R7 empty after zero load");

      // R8: collisions
      fl();
      op(1, 8'h5A, 0, 0, 1, 2, 32'h0000_BEEF); check_state("R8 load beats write");
      rd(); rd();
      op(0, '0, 0, 1, 1, 1, 32'h0000_00C7); check_state("R8 load beats flush");
      op(0, '0, 1, 1, 0, 0, '0); check_state("R8 flush beats read");
      op(1, 8'h3C, 1, 0, 0, 0, '0); check_state("R8 empty read drops write");
      wr(8'h61); op(1, 8'h62, 1, 0, 0, 0, '0); check_state("R8 read beats write");
      rd();

      repeat (2) @(negedge clk);
      chk("R5 scoreboard drained", exp_q.size(), 0);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL R1 watchdog: actual=running expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule